// File: doc/BRIEF.md
# Stall-Compensated BCD Divider

This block is the programmable divider of a phase-lock loop. It holds six BCD digits. When lock mode is requested, it waits for the frequency measurement in progress to finish. It then freezes that count as its modulus N and counts input pulses down. When the count passes below zero, the block reloads the modulus. A reload cannot take effect at once. While it settles, nine input pulses go to a small stall counter instead of the digits. To make up for those nine pulses and for the underflow pulse itself, ten is taken off the reloaded value once, during the stall. One full cycle therefore spans exactly N input pulses, and a one-cycle strobe marks each cycle.

The measurement unit supplies a strobe, together with the six digits it has just completed. The input-pulse strobe is a single-cycle qualifier. The block samples every input on the rising clock edge. Digits and strobe are registered, so they show the effect of a pulse in the cycle after that edge. Phase comparison happens outside the block.

Top module: `bcd_stall_divider`

## Requirements
- R1: After reset, digits_o is 000000 and wrap_o is low.
- R2: With lock_req_i high and no measurement strobe yet, input pulses leave digits_o at 000000 and wrap_o low.
- R3: When lock_req_i and meas_done_i are both high in idle, meas_digits_i is stored as the modulus and the digits are cleared. The stall counter is preset to its last count. The next pulse only hands counting to the digits, and digits_o stays 000000.
- R4: A pulse while counting with digits at 000000 loads the stored modulus into digits_o. On that same pulse, wrap_o is high for exactly one cycle.
- R5: The first three pulses after a wrap leave the digits unchanged. The fourth pulse subtracts ten once: the tens digit decrements, and the borrow ripples upward when the tens digit is 0 (100005 becomes 099995).
- R6: Pulses five to nine after a wrap leave the digits unchanged. The tenth pulse resumes counting down by one.
- R7: In down-counting, a digit decrements on a pulse only when all lower digits are 0, and a digit at 0 wraps to 9 (000100 becomes 000099).
- R8: For a modulus N of at least 10, consecutive wrap_o strobes are exactly N input pulses apart.
- R9: When lock_req_i is low, the next cycle shows digits_o at 000000 and wrap_o low, even if a pulse arrives in the same cycle. A new measurement strobe is needed before counting starts again.
- R10: While lock mode is active, meas_done_i is ignored and the stored modulus stays frozen.
- R11: digits_o[4k+3:4k] holds decimal digit k, with k=0 the least significant. Each nibble is always in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_req_i | input | 1 | Lock-mode request (level) |
| meas_done_i | input | 1 | Measurement complete strobe |
| meas_digits_i | input | 24 | Completed measurement, six BCD digits |
| pulse_i | input | 1 | Input pulse strobe |
| digits_o | output | 24 | Current six BCD digits |
| wrap_o | output | 1 | One-cycle strobe on each underflow reload |

## Verification
Two functions can fall in the same cycle:
- **Lock release and a counted pulse.** The bench raises pulse_i in the very cycle that lock_req_i falls. The pulse must be lost: digits_o reads 000000 with no wrap, rather than a decremented or reloaded value.
- **Stall compensation and a borrow across digits.** The tens-digit subtraction on the fourth stall pulse lands on a modulus whose tens digit is already 0. The result must show the borrow carried through the upper digits.

The 999999 walk checks that the hold windows of the stall sit around that single subtraction.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;
  localparam int unsigned DIG_W = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_STALL, ST_RUN} div_state_e;
endpackage

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain #(
  parameter int unsigned NDIG = 6,
  localparam int unsigned W = NDIG * bcd_div_pkg::DIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  input  logic         dec_tens_i,
  output logic [W-1:0] val_o,
  output logic         zero_o
);
  logic [NDIG:0] en;
  assign en[0] = dec_i;

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    logic [3:0] d_q;
    logic       lo_zero;
    assign lo_zero = (d_q == 4'd0);
    if (k == 0) begin : g_first
      assign en[k+1] = (en[k] && lo_zero) || dec_tens_i;
    end else begin : g_rest
      assign en[k+1] = en[k] && lo_zero;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      d_q <= 4'd0;
      else if (clr_i)   d_q <= 4'd0;
      else if (load_i)  d_q <= load_val_i[4*k +: 4];
      else if (en[k] || (k == 1 && dec_tens_i))
        d_q <= lo_zero ? 4'd9 : d_q - 4'd1;
    end
    assign val_o[4*k +: 4] = d_q;

    p_bcd_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      d_q <= 4'd9);
  end

  assign zero_o = (val_o == '0);

  // a nonzero units digit absorbs the decrement
  p_ripple_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !clr_i && !load_i && val_o[3:0] != 4'd0)
      |=> val_o[W-1:4] == $past(val_o[W-1:4]));
endmodule

// File: rtl/stall_ctr.sv
module stall_ctr #(
  parameter int unsigned STALL_LEN = 9,
  parameter int unsigned COMP_AT   = 4,
  localparam int unsigned CW = $clog2(STALL_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic preset_i,
  input  logic step_i,
  output logic comp_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign comp_o = step_i && (cnt_q == CW'(COMP_AT - 1));
  assign done_o = step_i && (cnt_q == CW'(STALL_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (preset_i)          cnt_q <= CW'(STALL_LEN - 1);
    else if (step_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_stall_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(STALL_LEN - 1));
endmodule

// File: rtl/bcd_stall_divider.sv
module bcd_stall_divider #(
  parameter int unsigned NDIG      = 6,
  parameter int unsigned STALL_LEN = 9,
  parameter int unsigned COMP_AT   = 4,
  localparam int unsigned W = NDIG * bcd_div_pkg::DIG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lock_req_i,
  input  logic         meas_done_i,
  input  logic [W-1:0] meas_digits_i,
  input  logic         pulse_i,
  output logic [W-1:0] digits_o,
  output logic         wrap_o
);
  import bcd_div_pkg::*;

  div_state_e   state_q;
  logic [W-1:0] mod_q;
  logic         enter, run_pulse, stall_pulse, wrap, zero, comp, done;

  assign enter       = (state_q == ST_IDLE) && lock_req_i && meas_done_i;
  assign run_pulse   = (state_q == ST_RUN) && lock_req_i && pulse_i;
  assign stall_pulse = (state_q == ST_STALL) && lock_req_i && pulse_i;
  assign wrap        = run_pulse && zero;

  bcd_digit_chain #(.NDIG(NDIG)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!lock_req_i || enter),
    .load_i     (wrap),
    .load_val_i (mod_q),
    .dec_i      (run_pulse && !zero),
    .dec_tens_i (comp),
    .val_o      (digits_o),
    .zero_o     (zero)
  );

  stall_ctr #(.STALL_LEN(STALL_LEN), .COMP_AT(COMP_AT)) u_stall (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wrap),
    .preset_i (enter),
    .step_i   (stall_pulse),
    .comp_o   (comp),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mod_q   <= '0;
      wrap_o  <= 1'b0;
    end else begin
      wrap_o <= wrap;
      if (enter) mod_q <= meas_digits_i;
      if (!lock_req_i)  state_q <= ST_IDLE;
      else if (enter)   state_q <= ST_STALL;
      else if (wrap)    state_q <= ST_STALL;
      else if (done)    state_q <= ST_RUN;
    end
  end

  p_wrap_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
  p_wrap_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> digits_o == mod_q);
  p_unlock_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_req_i |=> (digits_o == '0) && !wrap_o);
  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL && lock_req_i && !pulse_i) |=> $stable(digits_o));
  p_mod_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(mod_q));
endmodule

// File: tb/bcd_stall_divider_bench.sv
module bcd_stall_divider_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_req_i = 1'b0;
  logic        meas_done_i = 1'b0;
  logic [23:0] meas_digits_i = '0;
  logic        pulse_i = 1'b0;
  logic [23:0] digits_o;
  logic        wrap_o;
  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  bcd_stall_divider u_bcd_stall_divider (
    .clk_i, .rst_ni, .lock_req_i, .meas_done_i, .meas_digits_i,
    .pulse_i, .digits_o, .wrap_o
  );

  // {wrap, digits} after each pulse; entry 0 is the handoff pulse
  localparam logic [24:0] VEC [13] = '{
    25'h0_000000, 25'h1_999999, 25'h0_999999, 25'h0_999999, 25'h0_999999,
    25'h0_999989, 25'h0_999989, 25'h0_999989, 25'h0_999989, 25'h0_999989,
    25'h0_999989, 25'h0_999988, 25'h0_999987
  };

  task automatic chk(string tag, logic [23:0] exp_d, logic exp_w);
    checks++;
    if (digits_o !== exp_d || wrap_o !== exp_w) begin
      fails++;
      $display("FAIL %s: digits=%h wrap=%b expected digits=%h wrap=%b",
               tag, digits_o, wrap_o, exp_d, exp_w);
    end
  endtask

  task automatic pulse();
    pulse_i = 1'b1;
    @(negedge clk_i);
    pulse_i = 1'b0;
  endtask

  task automatic enter(logic [23:0] m);
    lock_req_i = 1'b0;
    @(negedge clk_i);
    lock_req_i    = 1'b1;
    meas_digits_i = m;
    meas_done_i   = 1'b1;
    @(negedge clk_i);
    meas_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk("R1 reset", 24'h000000, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 24'h000000, 1'b0);

    // R2: request without measurement strobe
    lock_req_i = 1'b1;
    repeat (3) pulse();
    chk("R2 no strobe", 24'h000000, 1'b0);

    // R3..R6 table walk with modulus 999999
    enter(24'h999999);
    chk("R3 entry clears", 24'h000000, 1'b0);
    for (int i = 0; i < 13; i++) begin
      pulse();
      chk($sformatf("R4/R5/R6 table step %0d", i), VEC[i][23:0], VEC[i][24]);
    end

    // R10: strobe ignored while locked
    meas_digits_i = 24'h000123;
    meas_done_i   = 1'b1;
    @(negedge clk_i);
    meas_done_i = 1'b0;
    chk("R10 strobe ignored", 24'h999987, 1'b0);

    // R9: release together with a pulse
    lock_req_i = 1'b0;
    pulse_i    = 1'b1;
    @(negedge clk_i);
    pulse_i = 1'b0;
    chk("R9 release wins", 24'h000000, 1'b0);
    lock_req_i = 1'b1;
    repeat (2) pulse();
    chk("R9 needs new strobe", 24'h000000, 1'b0);

    // R5 borrow ripple, R6 resume
    enter(24'h100005);
    pulse();
    pulse();
    chk("R4 wrap load 100005", 24'h100005, 1'b1);
    repeat (3) pulse();
    chk("R5 hold 3 pulses", 24'h100005, 1'b0);
    pulse();
    chk("R5 ripple subtract", 24'h099995, 1'b0);
    repeat (5) pulse();
    chk("R6 hold to ninth", 24'h099995, 1'b0);
    pulse();
    chk("R6 resume", 24'h099994, 1'b0);

    // R7 multi-digit borrow
    enter(24'h000110);
    repeat (2) pulse();
    repeat (9) pulse();
    chk("R7 after stall", 24'h000100, 1'b0);
    pulse();
    chk("R7 borrow 100->099", 24'h000099, 1'b0);
    pulse();
    chk("R7 units only", 24'h000098, 1'b0);

    // R8 period
    enter(24'h000025);
    repeat (2) pulse();
    chk("R8 first wrap", 24'h000025, 1'b1);
    for (int c = 0; c < 2; c++) begin
      n = 0;
      for (int i = 0; i < 40; i++) begin
        pulse();
        n++;
        if (wrap_o) break;
      end
      checks++;
      if (n != 25) begin
        fails++;
        $display("FAIL R8 period: got %0d expected 25", n);
      end
    end
    @(negedge clk_i);
    chk("R4 strobe one cycle", 24'h000025, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule